// File: doc/BRIEF.md
# Character Display Controller Host Port

This block is the processor-facing side of a two-line character display controller. A host reaches it over an 8-bit bus that can run in either of two strobe styles. In the first style, a single enable pulse is qualified by a direction line. In the second style, separate active-low read and write strobes are used. One select line picks between two host-visible registers. The instruction side accepts commands. Reading it returns a status byte that holds the busy flag and the address counter. The data side moves bytes to and from one of two internal memories: a display-data memory that holds character codes, and a smaller character-pattern memory.

A single address counter serves both memories. The most recent address instruction decides which memory it points into. Reads are prefetched. Setting an address, or finishing a data read, copies the addressed byte into the data register, so the byte is ready before the host asks for it. Every internal operation raises the busy flag for a fixed number of clocks. While the flag is high, writes are dropped and data reads do not advance. The clear command fills the display memory with blank codes one location per clock, so it stays busy for longer.

Top module: `chr_disp_hostif`

## Requirements
- R1: After reset: busy is 0, the address counter is 0, the entry direction is increment, the display memory is the target, and the data register is 00h.
- R2: With sel=0, dout is {busy, address counter in bits 6..0}. With sel=1, dout is the data register.
- R3: While busy is 1, a host write of either register is ignored, and completing a data read neither steps the counter nor reloads the data register.
- R4: With bus_mode=0, an access starts on the first clock that sees en high. rw=0 makes it a write, and rw=1 makes it a read that completes on the first clock that sees en low. With bus_mode=1, a write starts on the first clock that sees wr_n low, and a read completes on the first clock that sees rd_n high again. sel and din are sampled on the start clock.
- R5: Instruction codes are as follows. 1aaaaaaa sets a display address. 01aaaaaa sets a pattern address. 000001ix sets the entry direction, with i=1 meaning increment. 00000001 is clear. Every other code has no effect and does not raise busy.
- R6: An address instruction loads the counter, selects the target memory, and loads the data register with the byte at that address, so the first data read returns it.
- R7: A data write stores din at the counter's address in the target memory, places din in the data register, and steps the counter.
- R8: A completed data read steps the counter and then loads the data register from the new address.
- R9: A step adds or subtracts 1. The counter wraps within 7 bits for the display memory and within 6 bits for the pattern memory.
- R10: Busy is high for exactly OP_CYC clocks after any accepted instruction, data write or data read. For clear, it is high for the larger of CLR_CYC and the display memory depth.
- R11: Clear writes 20h into every display memory location, sets the counter to 0, selects increment, and makes the display memory the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | 0: enable plus direction strobes; 1: separate read/write strobes |
| sel | input | 1 | 0: instruction/status, 1: data register |
| rw | input | 1 | Direction in bus_mode 0 (1 = read) |
| en | input | 1 | Access enable in bus_mode 0 |
| rd_n | input | 1 | Active-low read strobe in bus_mode 1 |
| wr_n | input | 1 | Active-low write strobe in bus_mode 1 |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |

## Verification
A write acts on the clock edge that first sees its strobe. Busy is therefore visible in the next half cycle and stays high for exactly the specified count of samples. A data read acts on the edge that first sees the strobe released, which is one clock later. The bench samples every value half a cycle after the edge it depends on. It counts busy samples right after each write. After each read, it inserts one extra clock before counting. It compares the data byte on the bus while the read strobe is still active, before the prefetch replaces it. Blocked writes are issued while the previous operation is still busy, and their lack of effect is then read back through the status and data registers.

// File: rtl/chr_disp_pkg.sv
// Shared types and helpers for the character display host port.
// Assumes an 8-bit instruction byte.
package chr_disp_pkg;

    typedef enum logic [2:0] {
        INS_NONE,
        INS_SET_DD,
        INS_SET_CG,
        INS_ENTRY,
        INS_CLEAR
    } ins_e;

    localparam logic [7:0] BLANK_CODE = 8'h20;

    // Classify an instruction byte; the leading-one position decides.
    function automatic ins_e decode_ins(input logic [7:0] b);
        if (b[7])                    return INS_SET_DD;
        else if (b[6])               return INS_SET_CG;
        else if (b[7:2] == 6'b000001) return INS_ENTRY;
        else if (b == 8'h01)         return INS_CLEAR;
        else                         return INS_NONE;
    endfunction

endpackage

// File: rtl/chr_disp_busdec.sv
// Bus strobe decoder. Turns either strobe style into one-clock pulses:
// wr_stb on the clock that first sees a write strobe, rd_done on the clock
// that first sees a read strobe released. Assumes the strobes are
// synchronous to clk and that bus_mode only changes while the bus is idle.
module chr_disp_busdec (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode,
    input  logic sel,
    input  logic rw,
    input  logic en,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_stb,
    output logic wr_sel,
    output logic rd_done,
    output logic rd_sel
);
    logic en_q, rd_n_q, wr_n_q;
    logic rd_pend, rsel_q;
    logic rd_begin, rd_end;

    // Start and end edge detection for both modes.
    always_comb begin
        if (bus_mode) begin
            wr_stb   = ~wr_n & wr_n_q;
            rd_begin = ~rd_n & rd_n_q;
            rd_end   = rd_n & ~rd_n_q;
        end else begin
            wr_stb   = en & ~en_q & ~rw;
            rd_begin = en & ~en_q & rw;
            rd_end   = ~en & en_q;
        end
    end

    assign wr_sel  = sel;
    assign rd_done = rd_pend & rd_end;
    assign rd_sel  = rsel_q;

    // Previous strobe levels and the pending-read record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rd_n_q  <= 1'b1;
            wr_n_q  <= 1'b1;
            rd_pend <= 1'b0;
            rsel_q  <= 1'b0;
        end else begin
            en_q   <= en;
            rd_n_q <= rd_n;
            wr_n_q <= wr_n;
            if (rd_begin) begin
                rd_pend <= 1'b1;
                rsel_q  <= sel;
            end else if (rd_end) begin
                rd_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/chr_disp_ram.sv
// Single-write, single-read storage with asynchronous read.
// Contents are not reset.
module chr_disp_ram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chr_disp_busy.sv
// Busy timer. A start pulse loads a length, and busy stays high for exactly
// that many clocks. Assumes start is never raised while busy is high.
module chr_disp_busy #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/chr_disp_hostif.sv
// Host register port of a character display controller: instruction and
// data registers, a shared address counter for the display and pattern
// memories, read prefetch, entry direction, clear with blank fill, and a
// busy flag. Assumes DD_AW <= 7 and CG_AW < DD_AW.
module chr_disp_hostif #(
    parameter int DD_AW   = 7,
    parameter int CG_AW   = 6,
    parameter int OP_CYC  = 4,
    parameter int CLR_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_mode,
    input  logic       sel,
    input  logic       rw,
    input  logic       en,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    import chr_disp_pkg::*;

    localparam int DD_DEPTH = 1 << DD_AW;
    localparam int CLR_BUSY = (CLR_CYC > DD_DEPTH) ? CLR_CYC : DD_DEPTH;
    localparam int CNT_W    = $clog2(CLR_BUSY + 1);

    logic             wr_stb, wr_sel, rd_done, rd_sel, busy;
    logic [DD_AW-1:0] ac, ac_step, fill_idx;
    logic             tgt_cg, inc, clr_act;
    logic [7:0]       dr, dd_rdata, cg_rdata;
    ins_e             ins;
    logic             ir_go, dr_go, rd_go;
    logic             set_dd, set_cg, set_ent, set_clr;
    logic [DD_AW-1:0] dd_raddr, dd_waddr;
    logic [CG_AW-1:0] cg_raddr;
    logic [7:0]       dd_wdata;
    logic             dd_we, cg_we, op_start;
    logic [CNT_W-1:0] op_len;

    chr_disp_busdec u_busdec (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .sel(sel), .rw(rw),
        .en(en), .rd_n(rd_n), .wr_n(wr_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .rd_done(rd_done), .rd_sel(rd_sel)
    );

    // Accepted operations; everything is gated by busy.
    always_comb begin
        ins     = decode_ins(din);
        ir_go   = wr_stb & ~wr_sel & ~busy;
        dr_go   = wr_stb & wr_sel & ~busy;
        rd_go   = rd_done & rd_sel & ~busy & ~wr_stb;
        set_dd  = ir_go & (ins == INS_SET_DD);
        set_cg  = ir_go & (ins == INS_SET_CG);
        set_ent = ir_go & (ins == INS_ENTRY);
        set_clr = ir_go & (ins == INS_CLEAR);
    end

    // Next counter value under the current direction and target wrap.
    always_comb begin
        ac_step = inc ? ac + 1'b1 : ac - 1'b1;
        if (tgt_cg) ac_step[DD_AW-1:CG_AW] = '0;
    end

    // Memory port steering: prefetch address, clear fill, host writes.
    always_comb begin
        dd_raddr = set_dd ? din[DD_AW-1:0] : ac_step;
        cg_raddr = set_cg ? din[CG_AW-1:0] : ac_step[CG_AW-1:0];
        dd_we    = clr_act | (dr_go & ~tgt_cg);
        dd_waddr = clr_act ? fill_idx : ac;
        dd_wdata = clr_act ? BLANK_CODE : din;
        cg_we    = dr_go & tgt_cg;
    end

    chr_disp_ram #(.AW(DD_AW), .DW(8)) u_dd_ram (
        .clk(clk), .we(dd_we), .waddr(dd_waddr), .wdata(dd_wdata),
        .raddr(dd_raddr), .rdata(dd_rdata)
    );

    chr_disp_ram #(.AW(CG_AW), .DW(8)) u_cg_ram (
        .clk(clk), .we(cg_we), .waddr(ac[CG_AW-1:0]), .wdata(din),
        .raddr(cg_raddr), .rdata(cg_rdata)
    );

    // Busy length selection for the accepted operation.
    always_comb begin
        op_start = set_dd | set_cg | set_ent | set_clr | dr_go | rd_go;
        op_len   = set_clr ? CNT_W'(CLR_BUSY) : CNT_W'(OP_CYC);
    end

    chr_disp_busy #(.CNT_W(CNT_W)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(op_start), .len(op_len), .busy(busy)
    );

    // Register state: counter, target, direction, data register, clear fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac       <= '0;
            tgt_cg   <= 1'b0;
            inc      <= 1'b1;
            dr       <= '0;
            clr_act  <= 1'b0;
            fill_idx <= '0;
        end else begin
            if (clr_act) begin
                fill_idx <= fill_idx + 1'b1;
                if (fill_idx == DD_AW'(DD_DEPTH - 1)) clr_act <= 1'b0;
            end
            if (set_dd) begin
                ac     <= din[DD_AW-1:0];
                tgt_cg <= 1'b0;
                dr     <= dd_rdata;
            end else if (set_cg) begin
                ac     <= DD_AW'(din[CG_AW-1:0]);
                tgt_cg <= 1'b1;
                dr     <= cg_rdata;
            end else if (set_ent) begin
                inc <= din[1];
            end else if (set_clr) begin
                ac       <= '0;
                inc      <= 1'b1;
                tgt_cg   <= 1'b0;
                clr_act  <= 1'b1;
                fill_idx <= '0;
            end else if (dr_go) begin
                dr <= din;
                ac <= ac_step;
            end else if (rd_go) begin
                ac <= ac_step;
                dr <= tgt_cg ? cg_rdata : dd_rdata;
            end
        end
    end

    // Host read mux.
    assign dout = sel ? dr : {busy, 7'(ac)};
endmodule

// File: rtl/chr_disp_chk.sv
// Property checker for chr_disp_hostif, attached by bind.
module chr_disp_chk #(
    parameter int DD_AW = 7,
    parameter int CG_AW = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       din,
    input logic             wr_stb,
    input logic             wr_sel,
    input logic             rd_done,
    input logic             rd_sel,
    input logic             busy,
    input logic [DD_AW-1:0] ac,
    input logic             tgt_cg,
    input logic             inc,
    input logic             set_clr
);
    // R3: the counter does not move while an operation is in progress.
    a_r3_busy_freezes_ac: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ac));

    // R6: a display address instruction loads the counter and selects display.
    a_r6_set_dd_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_sel && !busy && din[7]) |=>
            (ac == $past(din[DD_AW-1:0]) && !tgt_cg));

    // R8: an accepted read in increment mode on display memory adds one.
    a_r8_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_sel && !busy && !wr_stb && inc && !tgt_cg) |=>
            (ac == DD_AW'($past(ac) + 1'b1)));

    // R9: the counter stays inside the pattern memory range.
    a_r9_cg_range: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cg |-> (ac[DD_AW-1:CG_AW] == '0));

    // R10: an accepted data write raises busy.
    a_r10_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel && !busy) |=> busy);

    // R11: clear resets counter, direction and target.
    a_r11_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        set_clr |=> (ac == '0 && inc && !tgt_cg && busy));
endmodule

bind chr_disp_hostif chr_disp_chk #(.DD_AW(DD_AW), .CG_AW(CG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .rd_done(rd_done), .rd_sel(rd_sel), .busy(busy), .ac(ac),
    .tgt_cg(tgt_cg), .inc(inc), .set_clr(set_clr)
);

// File: tb/chr_disp_hostif_bench.sv
`timescale 1ns/1ps
module chr_disp_hostif_bench;
    localparam int OP_CYC  = 4;
    localparam int CLR_CYC = 8;
    localparam int DD_N    = 128;
    localparam int CG_N    = 64;
    localparam int CLR_LEN = (CLR_CYC > DD_N) ? CLR_CYC : DD_N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_mode = 1'b0, sel = 1'b0, rw = 1'b0, en = 1'b0;
    logic rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;

    always #2 clk = ~clk;

    chr_disp_hostif #(.DD_AW(7), .CG_AW(6), .OP_CYC(OP_CYC), .CLR_CYC(CLR_CYC))
        u_chr_disp_hostif (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .sel(sel), .rw(rw),
        .en(en), .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m_dd [DD_N];
    logic [7:0] m_cg [CG_N];
    logic [6:0] m_ac = 7'h00;
    bit         m_tcg = 1'b0;
    bit         m_inc = 1'b1;
    logic [7:0] m_dr = 8'h00;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] nxt(input logic [6:0] a);
        logic [6:0] n;
        n = m_inc ? a + 7'd1 : a - 7'd1;
        return m_tcg ? {1'b0, n[5:0]} : n;
    endfunction

    task automatic drive_on(input logic s, input logic rd, input logic [7:0] d);
        sel = s;
        din = d;
        if (!bus_mode) begin
            rw = rd;
            en = 1'b1;
        end else if (rd) begin
            rd_n = 1'b0;
        end else begin
            wr_n = 1'b0;
        end
    endtask

    task automatic drive_off();
        en = 1'b0;
        rd_n = 1'b1;
        wr_n = 1'b1;
    endtask

    task automatic host_wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        drive_on(s, 1'b0, d);
        @(negedge clk);
        drive_off();
    endtask

    task automatic host_rd(input logic s, output logic [7:0] v);
        @(negedge clk);
        drive_on(s, 1'b1, 8'h00);
        #1 v = dout;
        @(negedge clk);
        drive_off();
    endtask

    task automatic busy_len(output int n);
        n = 0;
        sel = 1'b0;
        #1;
        while (dout[7] && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    // Instruction write with model update; busy length checked (R10, R5).
    task automatic op_ir(input logic [7:0] d);
        int exp_len, n;
        exp_len = 0;
        if (d[7]) begin
            m_ac = d[6:0]; m_tcg = 1'b0; m_dr = m_dd[m_ac]; exp_len = OP_CYC;
        end else if (d[6]) begin
            m_ac = {1'b0, d[5:0]}; m_tcg = 1'b1; m_dr = m_cg[d[5:0]]; exp_len = OP_CYC;
        end else if (d[7:2] == 6'b000001) begin
            m_inc = d[1]; exp_len = OP_CYC;
        end else if (d == 8'h01) begin
            for (int i = 0; i < DD_N; i++) m_dd[i] = 8'h20;
            m_ac = 7'h00; m_inc = 1'b1; m_tcg = 1'b0; exp_len = CLR_LEN;
        end
        host_wr(1'b0, d);
        busy_len(n);
        chk("R10", n, exp_len);
    endtask

    // Data write (R7).
    task automatic op_dw(input logic [7:0] d);
        int n;
        if (m_tcg) m_cg[m_ac[5:0]] = d; else m_dd[m_ac] = d;
        m_dr = d;
        m_ac = nxt(m_ac);
        host_wr(1'b1, d);
        busy_len(n);
        chk("R10", n, OP_CYC);
    endtask

    // Data read: value seen, then step and prefetch (R8).
    task automatic op_dr(input string req, input bit cmp);
        logic [7:0] v;
        int n;
        host_rd(1'b1, v);
        if (cmp) chk(req, v, m_dr);
        m_ac = nxt(m_ac);
        m_dr = m_tcg ? m_cg[m_ac[5:0]] : m_dd[m_ac];
        @(negedge clk);
        busy_len(n);
        chk("R10", n, OP_CYC);
    endtask

    task automatic op_st(input string req);
        logic [7:0] v;
        host_rd(1'b0, v);
        chk(req, v, {1'b0, m_ac});
    endtask

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state via status and data register.
        @(negedge clk);
        sel = 1'b0; #1 chk("R1", dout, 8'h00);
        sel = 1'b1; #1 chk("R1", dout, 8'h00);
        op_dr("R1", 1'b1);
        // R11: clear, then read back blanks through the prefetch path (R6).
        op_ir(8'h01);
        op_st("R11");
        op_ir(8'h83);
        op_st("R6");
        op_dr("R11", 1'b1);
        op_dr("R6", 1'b1);
        // R7: fill pattern memory; R9: 6-bit wrap back to 0.
        op_ir(8'h40);
        for (int i = 0; i < CG_N; i++) op_dw(8'($urandom));
        op_st("R9");
        op_ir(8'h7E);
        op_dr("R6", 1'b1);
        op_dr("R8", 1'b1);
        op_st("R9");
        // R9: 7-bit display wrap upward and downward.
        op_ir(8'hFF);
        op_dw(8'h5A);
        op_st("R9");
        op_ir(8'h04);
        op_ir(8'h80);
        op_dw(8'hA5);
        op_st("R9");
        op_ir(8'hFF);
        op_dr("R7", 1'b1);
        op_ir(8'h06);
        // R5: undefined codes do nothing and raise no busy.
        op_ir(8'h02);
        op_ir(8'h20);
        op_st("R5");
        // R3: writes issued during busy are dropped.
        m_ac = 7'h05; m_tcg = 1'b0; m_dr = m_dd[5];
        host_wr(1'b0, 8'h85);
        host_wr(1'b1, 8'hAA);
        host_wr(1'b0, 8'h01);
        busy_len(n);
        chk("R3", n, 0);
        op_st("R3");
        op_dr("R3", 1'b1);
        op_ir(8'h85);
        op_dr("R3", 1'b1);
        // R4: alternate strobe style, directed.
        bus_mode = 1'b1;
        op_ir(8'h90);
        op_dw(8'h3C);
        op_ir(8'h90);
        op_dr("R4", 1'b1);
        op_st("R4");
        // Random mix across both bus styles.
        for (int k = 0; k < 400; k++) begin
            int r;
            bus_mode = 1'($urandom);
            r = int'($urandom % 40);
            if (r == 0)       op_ir(8'h01);
            else if (r < 8)   op_ir({1'b1, 7'($urandom)});
            else if (r < 13)  op_ir({2'b01, 6'($urandom)});
            else if (r < 16)  op_ir({6'b000001, 2'($urandom)});
            else if (r < 25)  op_dw(8'($urandom));
            else if (r < 35)  op_dr("R8", 1'b1);
            else              op_st("R2");
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule